// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block watches eight external interrupt pins and one internal timer event. Each pin is brought into the clock domain by a two-flop synchronizer. A per-pin 2-bit mode then picks which pin transitions count: none, rising, falling, or both. A transition that counts sets a sticky flag for that pin. The timer event sets its own flag directly. Every flag drives one request line toward the interrupt controller, and a single combined line is high while any flag is set.

The pins form two groups. Pins 0 to 4 form the software group, whose flags clear only when software writes 0 to them. Pins 5 to 7 and the timer form the acknowledge group, whose flags also clear when the interrupt controller pulses the matching acknowledge bit. Software reaches the mode and flag registers through a simple register port. Writes take effect on a clock edge, and reads are combinational.

Top module: `eint_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, and `irq_req` and `irq_any` are 0.
- R2: The mode field of a pin selects which transitions set its flag: 00 selects none, 01 selects rising only, 10 selects falling only, 11 selects both.
- R3: A pin change applied between clock edges shows on `irq_req` after the third rising clock edge that follows, and not after the second.
- R4: A write to a flag register clears each flag whose written bit is 0. A written bit of 1 leaves its flag unchanged and never sets it.
- R5: A pulse on `int_ack[i]` clears only the acknowledge-group flag with index i. Bits 0 to 2 of `int_ack` map to pins 5 to 7, and bit 3 maps to the timer.
- R6: Flags of pins 0 to 4 are unaffected by `int_ack`.
- R7: When a flag's set condition and its clear condition (a software write of 0 or an acknowledge) occur in the same cycle, the flag ends the cycle at 1.
- R8: `irq_req[i]` equals flag i. Bits 0 to 7 are the pins and bit 8 is the timer. `irq_any` is high exactly when any flag is set.
- R9: The register map is as follows.
  - Address 0 holds the modes of pins 0 to 3, and address 1 holds the modes of pins 4 to 7. Pin 4j+k uses bits [2k+1:2k].
  - Address 2 holds the flags of pins 0 to 4 in bits [4:0].
  - Address 3 holds the flags of pins 5 to 7 in bits [2:0] and the timer flag in bit 7.
  - Unused bits and unused addresses read 0.
- R10: Writing a pin's mode field while the pin is steady creates no flag.
- R11: A `tmr_evt` high at a clock edge sets the timer flag at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | External interrupt pins, asynchronous |
| tmr_evt | input | 1 | Synchronous timer event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| int_ack | input | 4 | Acknowledge for pins 5 to 7 (bits 0 to 2) and the timer (bit 3) |
| irq_req | output | 9 | Per-source request, equal to the flags |
| irq_any | output | 1 | OR of all requests |

## Verification
Each flag is a request output, so a flag that is wrongly set or cleared shows on `irq_req` at the next clock edge. A corrupt mode field or synchronizer stage shows as a missing or extra request exactly three edges after a pin transition. The bench sweeps every pin through every mode and both transition directions. It checks the request vector at the cycle the latency predicts and one cycle earlier. It also races set against both kinds of clear in the same cycle.

// File: rtl/eint_pkg.sv
package eint_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam int REG_W = 8;
  localparam int PINS_PER_REG = REG_W / 2;
endpackage

// File: rtl/eint_pin_detect.sv
module eint_pin_detect
  import eint_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic [2*NPIN-1:0] mode_i,
  output logic [NPIN-1:0]   hit_o
);
  logic [NPIN-1:0] meta_q;
  logic [NPIN-1:0] sync_q;
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic rise, fall;
    edge_mode_e mode;
    assign rise = sync_q[g] & ~prev_q[g];
    assign fall = ~sync_q[g] & prev_q[g];
    assign mode = edge_mode_e'(mode_i[2*g+1:2*g]);
    always_comb begin
      unique case (mode)
        EDGE_RISE: hit_o[g] = rise;
        EDGE_FALL: hit_o[g] = fall;
        EDGE_BOTH: hit_o[g] = rise | fall;
        default:   hit_o[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/eint_mode_regs.sv
module eint_mode_regs
  import eint_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int AW   = 3,
  localparam int NREG = (NPIN + PINS_PER_REG - 1) / PINS_PER_REG
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [2*NPIN-1:0]     mode_o,
  output logic [NREG*REG_W-1:0] rd_o
);
  function automatic logic [REG_W-1:0] field_mask(int j);
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < PINS_PER_REG; k++)
      if (j * PINS_PER_REG + k < NPIN) m[2*k +: 2] = 2'b11;
    return m;
  endfunction

  logic [REG_W-1:0] mode_q [NREG];
  logic [REG_W-1:0] mode_n [NREG];

  always_comb begin
    for (int j = 0; j < NREG; j++) begin
      mode_n[j] = mode_q[j];
      if (wr_i && addr_i == AW'(j)) mode_n[j] = wdata_i & field_mask(j);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NREG; j++) mode_q[j] <= '0;
    end else begin
      for (int j = 0; j < NREG; j++) mode_q[j] <= mode_n[j];
    end
  end

  for (genvar j = 0; j < NREG; j++) begin : g_rd
    assign rd_o[j*REG_W +: REG_W] = mode_q[j];
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_fld
    assign mode_o[2*p+1:2*p] =
      mode_q[p / PINS_PER_REG][2*(p % PINS_PER_REG) +: 2];
  end
endmodule

// File: rtl/eint_flag_bank.sv
module eint_flag_bank #(
  parameter int NUM_SW  = 5,
  parameter int NUM_ACK = 3,
  localparam int NSRC = NUM_SW + NUM_ACK + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    set_i,
  input  logic               wr_sw_i,
  input  logic               wr_ack_i,
  input  logic [NUM_SW-1:0]  sw_wdata_i,
  input  logic [NUM_ACK:0]   ack_wdata_i,
  input  logic [NUM_ACK:0]   ack_i,
  output logic [NSRC-1:0]    flag_o
);
  logic [NSRC-1:0] flag_q, flag_n, clr;

  always_comb begin
    clr = '0;
    if (wr_sw_i)  clr[NUM_SW-1:0] = ~sw_wdata_i;
    if (wr_ack_i) clr[NSRC-1:NUM_SW] = ~ack_wdata_i;
    clr[NSRC-1:NUM_SW] = clr[NSRC-1:NUM_SW] | ack_i;
    flag_n = (flag_q & ~clr) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_n;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/eint_edge_ctrl.sv
module eint_edge_ctrl
  import eint_pkg::*;
#(
  parameter int NUM_SW  = 5,
  parameter int NUM_ACK = 3,
  parameter int AW      = 3,
  localparam int NPIN = NUM_SW + NUM_ACK,
  localparam int NSRC = NPIN + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  pin_in,
  input  logic             tmr_evt,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NUM_ACK:0] int_ack,
  output logic [NSRC-1:0]  irq_req,
  output logic             irq_any
);
  localparam int NREG = (NPIN + PINS_PER_REG - 1) / PINS_PER_REG;
  localparam logic [AW-1:0] A_FSW = AW'(NREG);
  localparam logic [AW-1:0] A_FACK = AW'(NREG + 1);

  logic [2*NPIN-1:0]     mode;
  logic [NREG*REG_W-1:0] mode_rd;
  logic [NPIN-1:0]       pin_hit;
  logic [NSRC-1:0]       src_hit;
  logic [NSRC-1:0]       flag;
  logic                  wr_sw, wr_ack;

  eint_mode_regs #(.NPIN(NPIN), .AW(AW)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .mode_o(mode), .rd_o(mode_rd)
  );

  eint_pin_detect #(.NPIN(NPIN)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mode_i(mode), .hit_o(pin_hit)
  );

  assign src_hit = {tmr_evt, pin_hit};
  assign wr_sw   = reg_wr && (reg_addr == A_FSW);
  assign wr_ack  = reg_wr && (reg_addr == A_FACK);

  eint_flag_bank #(.NUM_SW(NUM_SW), .NUM_ACK(NUM_ACK)) u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(src_hit),
    .wr_sw_i(wr_sw), .wr_ack_i(wr_ack),
    .sw_wdata_i(reg_wdata[NUM_SW-1:0]),
    .ack_wdata_i({reg_wdata[REG_W-1], reg_wdata[NUM_ACK-1:0]}),
    .ack_i(int_ack), .flag_o(flag)
  );

  always_comb begin
    reg_rdata = '0;
    for (int j = 0; j < NREG; j++)
      if (reg_addr == AW'(j)) reg_rdata = mode_rd[j*REG_W +: REG_W];
    if (reg_addr == A_FSW) reg_rdata = REG_W'(flag[NUM_SW-1:0]);
    if (reg_addr == A_FACK)
      reg_rdata = {flag[NSRC-1], {(REG_W-1-NUM_ACK){1'b0}}, flag[NPIN-1:NUM_SW]};
  end

  assign irq_req = flag;
  assign irq_any = |flag;
endmodule

// File: rtl/eint_edge_ctrl_chk.sv
module eint_edge_ctrl_chk #(
  parameter int NUM_SW  = 5,
  parameter int NUM_ACK = 3,
  parameter int AW      = 3,
  localparam int NPIN = NUM_SW + NUM_ACK,
  localparam int NSRC = NPIN + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic [NUM_ACK:0] int_ack,
  input logic [NSRC-1:0]  irq_req,
  input logic [NSRC-1:0]  src_hit
);
  localparam int NREG = (NPIN + 3) / 4;
  localparam logic [AW-1:0] A_FSW = AW'(NREG);
  localparam logic [7:0] SW_MASK = 8'((1 << NUM_SW) - 1);

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_hit) |=> ((irq_req & $past(src_hit)) == $past(src_hit))); // R7

  AST_SW_IGNORES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_FSW) |=>
      ((~irq_req[NUM_SW-1:0] & $past(irq_req[NUM_SW-1:0])) == '0)); // R6

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_FSW && src_hit[NUM_SW-1:0] == '0) |=>
      (irq_req[NUM_SW-1:0] ==
       ($past(irq_req[NUM_SW-1:0]) & $past(reg_wdata[NUM_SW-1:0])))); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~$past(irq_req) & ~$past(src_hit)) == '0); // R4

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(int_ack & ~src_hit[NSRC-1:NUM_SW])) |=>
      ((irq_req[NSRC-1:NUM_SW] & $past(int_ack & ~src_hit[NSRC-1:NUM_SW])) == '0)); // R5

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_FSW) |-> ((reg_rdata & ~SW_MASK) == 8'h00)); // R9
endmodule

bind eint_edge_ctrl eint_edge_ctrl_chk #(
  .NUM_SW(NUM_SW), .NUM_ACK(NUM_ACK), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_ack(int_ack),
  .irq_req(irq_req), .src_hit(src_hit)
);

// File: tb/eint_edge_ctrl_bench.sv
module eint_edge_ctrl_bench;
  logic       clk;
  logic       rst_n;
  logic [7:0] pin_in;
  logic       tmr_evt;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [3:0] int_ack;
  logic [8:0] irq_req;
  logic       irq_any;

  int nchk = 0;
  int nfail = 0;

  eint_edge_ctrl u_eint_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tmr_evt(tmr_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .int_ack(int_ack), .irq_req(irq_req),
    .irq_any(irq_any)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    nclk(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_flags();
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; pin_in = '0; tmr_evt = 1'b0; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0; int_ack = '0;
    nclk(3);
    rst_n = 1'b1;
    nclk(1);

    // R1 reset state
    chk("R1 irq_req", 32'(irq_req), 0);
    chk("R1 irq_any", 32'(irq_any), 0);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d);
      chk("R1 reg", 32'(d), 0);
    end

    // R2/R9 sweep: every pin, every mode, both directions
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] v;
        v = 8'(m << (2 * (p % 4)));
        wr(3'(p / 4), v);
        wr(3'(1 - p / 4), 8'h00);
        rd(3'(p / 4), d);
        chk("R9 mode readback", 32'(d), 32'(v));
        clear_flags();
        pin_in[p] = 1'b1;
        nclk(3);
        chk("R2 rising", 32'(irq_req), (m % 2 == 1) ? (32'd1 << p) : 0);
        chk("R8 any rising", 32'(irq_any), (m % 2 == 1) ? 1 : 0);
        clear_flags();
        pin_in[p] = 1'b0;
        nclk(3);
        chk("R2 falling", 32'(irq_req), (m >= 2) ? (32'd1 << p) : 0);
        clear_flags();
      end
    end

    // R3 latency
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h00);
    pin_in[0] = 1'b1;
    nclk(2);
    chk("R3 not after second edge", 32'(irq_req), 0);
    nclk(1);
    chk("R3 after third edge", 32'(irq_req), 1);
    pin_in[0] = 1'b0;
    nclk(3);
    clear_flags();

    // R4 write-zero clears, write-one no effect
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'hFF);
    rd(3'd1, d);
    chk("R9 full mode reg", 32'(d), 32'hFF);
    pin_in = 8'hFF;
    nclk(3);
    chk("R2 all pins", 32'(irq_req), 32'h0FF);
    wr(3'd2, 8'hFA);
    chk("R4 clear by zero", 32'(irq_req[4:0]), 32'h1A);
    rd(3'd2, d);
    chk("R9 sw flag read", 32'(d), 32'h1A);
    wr(3'd2, 8'hFF);
    chk("R4 one no effect", 32'(irq_req[4:0]), 32'h1A);

    // R6 ack does not touch software group
    int_ack = 4'hF;
    nclk(1);
    int_ack = 4'h0;
    chk("R6 sw group kept", 32'(irq_req[4:0]), 32'h1A);
    chk("R5 ack group cleared", 32'(irq_req[8:5]), 0);

    // R5 per-bit ack
    pin_in = 8'h00;
    nclk(3);
    chk("R2 all falling", 32'(irq_req), 32'h0FF);
    int_ack = 4'b0010;
    nclk(1);
    int_ack = 4'h0;
    chk("R5 single ack", 32'(irq_req[8:5]), 32'b0101);

    // R11 timer event
    tmr_evt = 1'b1;
    nclk(1);
    tmr_evt = 1'b0;
    chk("R11 timer set", 32'(irq_req[8]), 1);
    rd(3'd3, d);
    chk("R9 ack flag read", 32'(d), 32'h85);
    int_ack = 4'b1000;
    nclk(1);
    int_ack = 4'h0;
    chk("R5 timer ack", 32'(irq_req[8:5]), 32'b0101);
    tmr_evt = 1'b1;
    nclk(1);
    tmr_evt = 1'b0;
    wr(3'd3, 8'h7F);
    chk("R4 timer write zero", 32'(irq_req[8:5]), 32'b0101);
    rd(3'd3, d);
    chk("R9 ack flag read2", 32'(d), 32'h05);

    // R8 combined request
    clear_flags();
    chk("R8 any low", 32'(irq_any), 0);
    tmr_evt = 1'b1;
    nclk(1);
    tmr_evt = 1'b0;
    chk("R8 timer only", 32'(irq_req), 32'h100);
    chk("R8 any high", 32'(irq_any), 1);
    clear_flags();

    // R7 set beats clear
    pin_in[0] = 1'b1;
    nclk(2);
    wr(3'd2, 8'h00);
    chk("R7 set beats write", 32'(irq_req[0]), 1);
    pin_in[5] = 1'b1;
    nclk(2);
    int_ack = 4'b0001;
    nclk(1);
    int_ack = 4'h0;
    chk("R7 set beats ack", 32'(irq_req[5]), 1);
    tmr_evt = 1'b1;
    int_ack = 4'b1000;
    nclk(1);
    tmr_evt = 1'b0;
    int_ack = 4'h0;
    chk("R7 timer set beats ack", 32'(irq_req[8]), 1);
    clear_flags();
    tmr_evt = 1'b1;
    wr(3'd3, 8'h00);
    tmr_evt = 1'b0;
    chk("R7 timer set beats write", 32'(irq_req[8]), 1);
    clear_flags();
    chk("R4 all cleared", 32'(irq_req), 0);

    // R10 mode write on steady pin creates no flag
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    pin_in = 8'hFF;
    nclk(4);
    chk("R2 mode off", 32'(irq_req), 0);
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'hFF);
    nclk(4);
    chk("R10 no event on mode write", 32'(irq_req), 0);
    pin_in = 8'h00;
    nclk(3);
    chk("R10 modes active", 32'(irq_req), 32'h0FF);

    // R9 unused addresses
    rd(3'd4, d);
    chk("R9 unused addr 4", 32'(d), 0);
    rd(3'd7, d);
    chk("R9 unused addr 7", 32'(d), 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule